// File: doc/BRIEF.md
# Multi-Pass 3x3 Convolution Engine

This block is a fixed-point convolution datapath whose only arithmetic element is a 3x3 multiply-accumulate kernel: nine signed pixel taps times nine signed coefficients, summed to one value per image lane. Several image lanes run in lockstep and read one shared coefficient set, so adding lanes adds no coefficient traffic. The same kernel serves fully connected layers as a plain nine-element dot product.

Square filters larger than 3x3 are handled upstream by cutting them into 3x3 tiles, with zero coefficients in unused tile positions: a 5x5 filter becomes 4 passes and an 11x11 filter 16 passes. Each lane holds a wide partial sum across the passes. A window flagged as the first pass restarts the sum, every accepted window adds into it, and only a window flagged as the last pass produces a result, saturated to 24 bits. A coefficient set is loaded tap by tap and then stays in place for a whole feature map, which may be hundreds of output positions long.

The result stream uses valid/ready. While a result waits, the whole pipeline holds and no new window is accepted, so no partial sum is ever dropped.

Top module: `mpconv_engine`

## Requirements
- R1: For each lane, a result equals the sum over taps k = 0..8 of pixel k times coefficient k, all operands 10-bit two's complement. Pixel k of lane l sits at bits [(l*9+k)*10 +: 10] of `win_pix_i`; lane l's result sits at bits [l*24 +: 24] of `res_data_o`.
- R2: A window with `win_first_i` high restarts the lane sum with its own pass value; any other accepted window adds its pass value to the held sum. Only a window with `win_last_i` high produces a result; other windows raise no `res_valid_o`.
- R3: With no back-pressure, a last-pass window accepted in cycle t gives `res_valid_o` high in cycle t+3 and not before.
- R4: All lanes use the same coefficient set, and each lane's result depends only on its own pixels.
- R5: A load starts when `wl_start_i` is high while `wl_ready_o` is high. `wl_ready_o` is low while any accepted window has not yet reached the accumulator. From an accepted start until the cycle tap index 8 is written, `win_ready_o` is low; taps 0..8 are written through `wl_tap_idx_i`/`wl_tap_data_i` with `wl_tap_valid_i`. The new set applies to every window accepted after the tap-8 cycle.
- R6: Results are clipped to the range -8388608..8388607. `ovf_o` goes high in the cycle the first clipped result appears, stays high, and is cleared by an accepted load start.
- R7: While `res_valid_o` is high and `res_ready_i` low, `res_data_o` and `res_valid_o` hold and `win_ready_o` is low; all sums resume correctly afterwards.
- R8: A loaded coefficient set stays unchanged across any number of windows (at least a 169-position map) until the next load.
- R9: After reset, `res_valid_o` and `ovf_o` are low, both ready outputs are high and all coefficients are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wl_start_i | input | 1 | Request to begin a coefficient load |
| wl_ready_o | output | 1 | Load start may be accepted |
| wl_tap_valid_i | input | 1 | Coefficient tap write strobe |
| wl_tap_idx_i | input | 4 | Tap index 0..8, row-major |
| wl_tap_data_i | input | 10 | Signed coefficient value |
| win_valid_i | input | 1 | Window present |
| win_ready_o | output | 1 | Window accepted this cycle when valid |
| win_first_i | input | 1 | Window is the first pass of a filter |
| win_last_i | input | 1 | Window is the last pass of a filter |
| win_pix_i | input | LANES*90 | Nine signed pixels per lane |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | LANES*24 | Saturated result per lane |
| ovf_o | output | 1 | Sticky clipping flag |

## Verification
The bench builds the block with its default parameters: four lanes, 10-bit operands, a 28-bit accumulator and a 24-bit result. With these widths, full-scale pixels and coefficients cross the 24-bit limit in either direction within four passes, so both clipping corners and the overflow flag are reached, while sixteen-pass runs still fit the accumulator exactly. Four lanes are enough to show that distinct per-lane pixels under one shared coefficient set give distinct results, and random pass counts with random back-pressure exercise stalls at every pipeline position.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;
  localparam int TAPS     = 9;
  localparam int GRP      = 3;
  localparam int GROUPS   = TAPS / GRP;
  localparam int IDXW     = $clog2(TAPS);
  localparam int LAST_TAP = TAPS - 1;
endpackage

// File: rtl/mpc_coef_bank.sv
`timescale 1ns/1ps
module mpc_coef_bank import mpc_pkg::*; #(
  parameter int DW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 tap_we_i,
  input  logic [IDXW-1:0]      tap_idx_i,
  input  logic [DW-1:0]        tap_data_i,
  output logic                 loading_o,
  output logic [TAPS*DW-1:0]   coef_o
);
  logic          loading_q;
  logic [DW-1:0] coef_q [TAPS];
  logic          wr_en;

  assign wr_en = tap_we_i && loading_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loading_q <= 1'b0;
    end else if (start_i) begin
      loading_q <= 1'b1;
    end else if (wr_en && tap_idx_i == IDXW'(LAST_TAP)) begin
      loading_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) coef_q[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < TAPS; k++)
        if (tap_idx_i == IDXW'(k)) coef_q[k] <= tap_data_i;
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_pack
    assign coef_o[k*DW +: DW] = coef_q[k];
  end

  assign loading_o = loading_q;

  // R8
  coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loading_q |=> $stable(coef_o));
endmodule

// File: rtl/mpc_flow.sv
`timescale 1ns/1ps
module mpc_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_valid_i,
  input  logic win_first_i,
  input  logic win_last_i,
  input  logic res_ready_i,
  input  logic loading_i,
  input  logic wl_start_i,
  output logic win_ready_o,
  output logic wl_ready_o,
  output logic start_acc_o,
  output logic res_valid_o,
  output logic adv_o,
  output logic v2_o,
  output logic first2_o,
  output logic last2_o
);
  logic v1_q, f1_q, l1_q;
  logic v2_q, f2_q, l2_q;
  logic rv_q;
  logic adv, pipe_empty, win_fire;

  // whole pipe holds while a result waits
  assign adv         = !(rv_q && !res_ready_i);
  assign pipe_empty  = !v1_q && !v2_q;
  assign wl_ready_o  = loading_i || pipe_empty;
  assign start_acc_o = wl_start_i && wl_ready_o;
  assign win_ready_o = adv && !loading_i && !start_acc_o;
  assign win_fire    = win_valid_i && win_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; f1_q <= 1'b0; l1_q <= 1'b0;
      v2_q <= 1'b0; f2_q <= 1'b0; l2_q <= 1'b0;
    end else if (adv) begin
      v1_q <= win_fire; f1_q <= win_first_i; l1_q <= win_last_i;
      v2_q <= v1_q;     f2_q <= f1_q;        l2_q <= l1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rv_q <= 1'b0;
    else if (adv && v2_q && l2_q) rv_q <= 1'b1;
    else if (res_ready_i)         rv_q <= 1'b0;
  end

  assign res_valid_o = rv_q;
  assign adv_o       = adv;
  assign v2_o        = v2_q;
  assign first2_o    = f2_q;
  assign last2_o     = l2_q;

  // R3
  stage_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && v1_q) |=> v2_q);
endmodule

// File: rtl/mpc_lane_mac.sv
`timescale 1ns/1ps
module mpc_lane_mac import mpc_pkg::*; #(
  parameter int DW   = 10,
  parameter int ACCW = 28,
  parameter int OUTW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic                 v2_i,
  input  logic                 first2_i,
  input  logic                 last2_i,
  input  logic [TAPS*DW-1:0]   coef_i,
  input  logic [TAPS*DW-1:0]   pix_i,
  output logic [OUTW-1:0]      res_o,
  output logic                 clip_o
);
  localparam int PRW = 2 * DW;
  localparam int GW  = PRW + 2;
  localparam int SW  = PRW + 4;
  localparam logic signed [ACCW-1:0] SAT_HI = {{(ACCW-OUTW+1){1'b0}}, {(OUTW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SAT_LO = {{(ACCW-OUTW+1){1'b1}}, {(OUTW-1){1'b0}}};

  logic signed [DW-1:0]   px [TAPS];
  logic signed [DW-1:0]   cf [TAPS];
  logic signed [PRW-1:0]  prod_q [TAPS];
  logic signed [GW-1:0]   grp_q [GROUPS];
  logic signed [SW-1:0]   pass_sum;
  logic signed [ACCW-1:0] acc_q, acc_nxt;
  logic [OUTW-1:0]        res_q;
  logic                   upd, fin, over, under;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign px[k] = pix_i[k*DW +: DW];
    assign cf[k] = coef_i[k*DW +: DW];
  end

  // stage 1: products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
    end else if (adv_i) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= PRW'(px[k]) * PRW'(cf[k]);
    end
  end

  // stage 2: row sums
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < GROUPS; g++) grp_q[g] <= '0;
    end else if (adv_i) begin
      for (int g = 0; g < GROUPS; g++)
        grp_q[g] <= GW'(prod_q[g*GRP]) + GW'(prod_q[g*GRP+1]) + GW'(prod_q[g*GRP+2]);
    end
  end

  // stage 3: pass total into accumulator
  always_comb begin
    pass_sum = '0;
    for (int g = 0; g < GROUPS; g++) pass_sum = pass_sum + SW'(grp_q[g]);
  end

  assign acc_nxt = first2_i ? ACCW'(pass_sum) : acc_q + ACCW'(pass_sum);
  assign upd     = adv_i && v2_i;
  assign fin     = upd && last2_i;
  assign over    = acc_nxt > SAT_HI;
  assign under   = acc_nxt < SAT_LO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  acc_q <= '0;
    else if (upd) acc_q <= acc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (fin) begin
      res_q <= over ? SAT_HI[OUTW-1:0] : under ? SAT_LO[OUTW-1:0] : acc_nxt[OUTW-1:0];
    end
  end

  assign res_o  = res_q;
  assign clip_o = fin && (over || under);
endmodule

// File: rtl/mpconv_engine.sv
`timescale 1ns/1ps
module mpconv_engine import mpc_pkg::*; #(
  parameter int LANES = 4,
  parameter int DW    = 10,
  parameter int ACCW  = 28,
  parameter int OUTW  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wl_start_i,
  output logic                      wl_ready_o,
  input  logic                      wl_tap_valid_i,
  input  logic [IDXW-1:0]           wl_tap_idx_i,
  input  logic [DW-1:0]             wl_tap_data_i,
  input  logic                      win_valid_i,
  output logic                      win_ready_o,
  input  logic                      win_first_i,
  input  logic                      win_last_i,
  input  logic [LANES*TAPS*DW-1:0]  win_pix_i,
  output logic                      res_valid_o,
  input  logic                      res_ready_i,
  output logic [LANES*OUTW-1:0]     res_data_o,
  output logic                      ovf_o
);
  localparam int LPW = TAPS * DW;

  logic               loading, start_acc, adv, v2, first2, last2;
  logic [LPW-1:0]     coef;
  logic [LANES-1:0]   clip;
  logic               ovf_q;

  mpc_coef_bank #(.DW(DW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_acc),
    .tap_we_i   (wl_tap_valid_i),
    .tap_idx_i  (wl_tap_idx_i),
    .tap_data_i (wl_tap_data_i),
    .loading_o  (loading),
    .coef_o     (coef)
  );

  mpc_flow u_flow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_valid_i (win_valid_i),
    .win_first_i (win_first_i),
    .win_last_i  (win_last_i),
    .res_ready_i (res_ready_i),
    .loading_i   (loading),
    .wl_start_i  (wl_start_i),
    .win_ready_o (win_ready_o),
    .wl_ready_o  (wl_ready_o),
    .start_acc_o (start_acc),
    .res_valid_o (res_valid_o),
    .adv_o       (adv),
    .v2_o        (v2),
    .first2_o    (first2),
    .last2_o     (last2)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    mpc_lane_mac #(.DW(DW), .ACCW(ACCW), .OUTW(OUTW)) u_mac (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .v2_i     (v2),
      .first2_i (first2),
      .last2_i  (last2),
      .coef_i   (coef),
      .pix_i    (win_pix_i[l*LPW +: LPW]),
      .res_o    (res_data_o[l*OUTW +: OUTW]),
      .clip_o   (clip[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (start_acc) ovf_q <= 1'b0;
    else if (|clip)     ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

  // R5
  load_blocks_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loading |-> !win_ready_o);

  // R7
  res_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !wl_start_i) |=> ovf_o);
endmodule

// File: tb/tb_mpconv_engine.sv
`timescale 1ns/1ps
module tb_mpconv_engine;
  localparam int LANES = 4, DW = 10, ACCW = 28, OUTW = 24, TAPS = 9;
  localparam int PIXW  = LANES * TAPS * DW;
  localparam longint HI = 8388607, LO = -8388608;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              wl_start = 0, wl_tap_valid = 0;
  logic [3:0]        wl_tap_idx = '0;
  logic [DW-1:0]     wl_tap_data = '0;
  logic              win_valid = 0, win_first = 0, win_last = 0, res_ready = 1;
  logic [PIXW-1:0]   win_pix = '0;
  logic              wl_ready_o, win_ready_o, res_valid_o, ovf_o;
  logic [LANES*OUTW-1:0] res_data_o;

  mpconv_engine #(.LANES(LANES), .DW(DW), .ACCW(ACCW), .OUTW(OUTW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wl_start_i(wl_start), .wl_ready_o(wl_ready_o),
    .wl_tap_valid_i(wl_tap_valid), .wl_tap_idx_i(wl_tap_idx), .wl_tap_data_i(wl_tap_data),
    .win_valid_i(win_valid), .win_ready_o(win_ready_o),
    .win_first_i(win_first), .win_last_i(win_last), .win_pix_i(win_pix),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready), .res_data_o(res_data_o),
    .ovf_o(ovf_o)
  );

  int errors = 0, checks = 0, wd = 0;
  string req = "R9";

  // behavioural reference state
  longint coef_m [TAPS];
  longint acc_m  [LANES];
  bit     load_m = 0, ovf_m = 0, outv_m = 0;
  logic [LANES*OUTW-1:0] outd_m = '0;
  int     fl_cnt [$];
  bit     fl_last [$];
  bit     fl_clip [$];
  logic [LANES*OUTW-1:0] fl_data [$];
  bit     win_acc = 0, start_acc = 0;

  task automatic check(string r, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic model_cycle();
    bit adv, wlr, wnr, clipped;
    longint s, a, d;
    logic [LANES*OUTW-1:0] dat;
    adv   = !(outv_m && !res_ready);
    wlr   = load_m || (fl_cnt.size() == 0);
    start_acc = wl_start && wlr;
    wnr   = adv && !load_m && !start_acc;
    win_acc = win_valid && wnr;
    check(req, "wl_ready", wl_ready_o, wlr);
    check(req, "win_ready", win_ready_o, wnr);
    check(req, "res_valid", res_valid_o, outv_m);
    check(req, "ovf", ovf_o, ovf_m);
    if (outv_m)
      for (int l = 0; l < LANES; l++) begin
        a = $signed(res_data_o[l*OUTW +: OUTW]);
        d = $signed(outd_m[l*OUTW +: OUTW]);
        check(req, "res_data", a, d);
      end
    if (outv_m && res_ready) outv_m = 0;
    if (adv) begin
      foreach (fl_cnt[i]) fl_cnt[i]--;
      while (fl_cnt.size() > 0 && fl_cnt[0] == 0) begin
        if (fl_last[0]) begin
          outv_m = 1; outd_m = fl_data[0];
          if (fl_clip[0]) ovf_m = 1;
        end
        void'(fl_cnt.pop_front()); void'(fl_last.pop_front());
        void'(fl_clip.pop_front()); void'(fl_data.pop_front());
      end
    end
    if (load_m && wl_tap_valid) begin
      if (wl_tap_idx < TAPS) coef_m[wl_tap_idx] = longint'($signed(wl_tap_data));
      if (wl_tap_idx == TAPS-1) load_m = 0;
    end
    if (start_acc) begin load_m = 1; ovf_m = 0; end
    if (win_acc) begin
      clipped = 0; dat = '0;
      for (int l = 0; l < LANES; l++) begin
        s = 0;
        for (int k = 0; k < TAPS; k++)
          s += longint'($signed(win_pix[(l*TAPS+k)*DW +: DW])) * coef_m[k];
        acc_m[l] = win_first ? s : acc_m[l] + s;
        d = acc_m[l];
        if (d > HI) begin d = HI; clipped = 1; end
        if (d < LO) begin d = LO; clipped = 1; end
        dat[l*OUTW +: OUTW] = d[OUTW-1:0];
      end
      fl_cnt.push_back(2); fl_last.push_back(win_last);
      fl_clip.push_back(win_last && clipped); fl_data.push_back(dat);
    end
  endtask

  task automatic step();
    @(negedge clk);
    model_cycle();
    @(posedge clk); #1;
  endtask

  task automatic probe(string r, longint e0, longint elast);
    @(negedge clk);
    check(r, "probe valid", res_valid_o, 1);
    check(r, "probe lane0", $signed(res_data_o[0 +: OUTW]), e0);
    check(r, "probe lastlane", $signed(res_data_o[(LANES-1)*OUTW +: OUTW]), elast);
    model_cycle();
    @(posedge clk); #1;
  endtask

  task automatic load_weights(int base, int stride);
    wl_start = 1;
    do step(); while (!start_acc);
    wl_start = 0;
    for (int k = 0; k < TAPS; k++) begin
      wl_tap_valid = 1; wl_tap_idx = 4'(k); wl_tap_data = DW'(base + stride*k);
      step();
    end
    wl_tap_valid = 0;
  endtask

  task automatic send_window(bit f, bit l);
    win_valid = 1; win_first = f; win_last = l;
    do step(); while (!win_acc);
    win_valid = 0;
  endtask

  task automatic fill_lane(int lane, int v);
    for (int k = 0; k < TAPS; k++) win_pix[(lane*TAPS+k)*DW +: DW] = DW'(v);
  endtask

  task automatic rand_pix();
    for (int i = 0; i < LANES*TAPS; i++) win_pix[i*DW +: DW] = DW'($urandom_range(0, 1023));
  endtask

  task automatic stream(int n, int pct);
    int np = 1 + $urandom_range(0, 3), pi = 0;
    rand_pix(); win_first = 1; win_last = (np == 1); win_valid = 1;
    for (int i = 0; i < n; i++) begin
      res_ready = ($urandom_range(0, 99) < pct);
      step();
      if (win_acc) begin
        pi++;
        if (pi == np) begin pi = 0; np = 1 + $urandom_range(0, 3); end
        rand_pix(); win_first = (pi == 0); win_last = (pi == np - 1);
      end
    end
    win_valid = 0; res_ready = 1;
    repeat (6) step();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", wd, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (coef_m[k]) coef_m[k] = 0;
    foreach (acc_m[l])  acc_m[l] = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R9 reset state, zero coefficients give zero
    req = "R9";
    step();
    rand_pix(); send_window(1, 1);
    step(); step(); probe("R9", 0, 0);

    // R5 load requested right behind two windows in flight
    req = "R5";
    send_window(1, 1); send_window(1, 1);
    check("R5", "wl_ready busy", wl_ready_o, 0);
    load_weights(1, 1);
    rand_pix(); send_window(1, 1);
    repeat (4) step();

    // R1 / R4 / R3 directed dot products
    req = "R1";
    for (int l = 0; l < LANES; l++) fill_lane(l, l + 1);
    send_window(1, 1);
    step();
    check("R3", "early valid", res_valid_o, 0);
    step(); probe("R4", 45, 45 * LANES);
    for (int l = 0; l < LANES; l++) fill_lane(l, -1);
    send_window(1, 1); step(); step(); probe("R1", -45, -45);

    // R2 multi-pass: 4 and 16 passes
    req = "R2";
    for (int p = 0; p < 4; p++) begin fill_lane(0, 1); fill_lane(LANES-1, 2); send_window(p == 0, p == 3); end
    step(); step(); probe("R2", 180, 360);
    for (int p = 0; p < 16; p++) begin rand_pix(); send_window(p == 0, p == 15); end
    repeat (5) step();

    // R7 directed hold under back-pressure
    req = "R7";
    for (int l = 0; l < LANES; l++) fill_lane(l, 1);
    res_ready = 0;
    send_window(1, 1);
    win_valid = 1; win_first = 1; win_last = 1;
    repeat (6) step();
    check("R7", "held lane0", $signed(res_data_o[0 +: OUTW]), 45);
    check("R7", "win blocked", win_ready_o, 0);
    res_ready = 1;
    do step(); while (!win_acc);
    win_valid = 0;
    repeat (5) step();

    // R6 saturation both ways, sticky flag, cleared by load
    req = "R6";
    load_weights(511, 0);
    for (int p = 0; p < 4; p++) begin fill_lane(0, 511); fill_lane(LANES-1, -512); send_window(p == 0, p == 3); end
    step(); step(); probe("R6", HI, LO);
    check("R6", "ovf set", ovf_o, 1);
    send_window(1, 1); repeat (4) step();
    check("R6", "ovf sticky", ovf_o, 1);
    load_weights(1, 1);
    check("R6", "ovf cleared", ovf_o, 0);

    // R8 one set held over a 169-position map
    req = "R8";
    win_valid = 1; win_first = 1; win_last = 1;
    for (int i = 0; i < 169; i++) begin rand_pix(); do step(); while (!win_acc); end
    win_valid = 0;
    for (int l = 0; l < LANES; l++) fill_lane(l, 1);
    send_window(1, 1); step(); step(); probe("R8", 45, 45);

    // random passes, with and without back-pressure
    req = "R2"; stream(300, 100);
    req = "R7"; stream(500, 55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule